// File: doc/BRIEF.md
# Dual-Mode Clock Enable Generator

This block turns one source clock into two rate-controlled enable strobes: a core strobe and a bus strobe. Each strobe is one source cycle wide, and downstream logic uses it as a synchronous clock enable. The block never gates a clock. Each generator runs in one of two modes, chosen by its own bit of the `rate_mode` input.

In accumulator mode, a 6-bit phase value is added to a 6-bit accumulator on every source strobe, and the carry out of that addition marks an output strobe. This gives a rate of source × phase / 64. In divider mode, the generator emits one strobe for every phase+1 source strobes.

The core generator's source is the block clock itself. The bus generator's source is either the block clock or the core strobe, chosen by a select bit. An idle-disable bit lets the `idle` input silence the bus strobe.

Both phase values, the select bit and the idle-disable bit sit in one 32-bit configuration word. That word is written through a single-cycle write port and can always be read back.

A new setting is not applied in the middle of a period. Each generator holds its active setting until its next strobe, then takes up the new one with a cleared counter. This way no short or extra strobe appears when the setting changes.

Top module: `dual_clk_enable_gen`

## Requirements
- R1: In accumulator mode, with an active phase p in 1..32, a generator emits exactly p strobes in any 64 consecutive source strobes. The values 1, 2, 4, 8, 16 and 32 give even spacing; other values give uneven spacing.
- R2: In accumulator mode, a phase of 0 makes the generator pass every source strobe through.
- R3: In accumulator mode, a phase above 32 is treated as 32. Whenever a field holds such a value while its mode bit is 0, `phase_err` rises one cycle later and stays at 1 until reset.
- R4: In divider mode, a generator emits one strobe every p+1 source strobes, for any p in 0..63.
- R5: The configuration word maps as follows: bits 5:0 core phase, bits 13:8 bus phase, bit 14 idle bus disable, bit 15 bus source select. Bits 7:6 and 31:16 always read 0. `cfg_rdata` shows the stored word in the cycle after a write.
- R6: After reset, `cfg_rdata` reads 0x00002000 (bus phase 32, everything else 0) and `phase_err` is 0.
- R7: With bit 15 at 0, the bus generator counts every clock. With bit 15 at 1, it counts only clocks in which `core_stb` is 1, so `bus_stb` can be 1 only together with `core_stb`.
- R8: With bit 14 at 1 and `idle` at 1, `bus_stb` is 0. With bit 14 at 0, `idle` has no effect on `bus_stb`.
- R9: `rate_mode[0]` selects divider mode (1) or accumulator mode (0) for the core generator, and `rate_mode[1]` does the same for the bus generator, independently.
- R10: A generator's active setting changes only in a cycle that follows one of its own strobes, and the change clears its counter. Every gap between strobes is therefore a full period of either the old or the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration data to write |
| cfg_rdata | output | 32 | Stored configuration word, reserved bits zero |
| rate_mode | input | 2 | Per-generator mode: bit 0 core, bit 1 bus; 1 = divider |
| idle | input | 1 | Idle request from the power controller |
| core_stb | output | 1 | Core clock enable strobe |
| bus_stb | output | 1 | Bus clock enable strobe |
| phase_err | output | 1 | Sticky flag: an illegal accumulator phase was seen |

## Verification
The assertions assume that `rate_mode`, `idle` and the write port change only between clock edges. They also assume that reset is held for at least one edge, so the active settings start from their reset values.

The stimulus meets these assumptions because every input is driven on the falling clock edge. Before each rate measurement the bench waits longer than the slowest possible old period, so each count starts with the new setting in place. Every measurement window is a whole number of periods, so the expected count does not depend on the accumulator phase at which the window opens.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int REG_W        = 32;
  localparam int PHASE_W      = 6;
  localparam int CORE_LSB     = 0;
  localparam int BUS_LSB      = 8;
  localparam int IDLE_DIS_BIT = 14;
  localparam int BUS_SEL_BIT  = 15;
  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'((1 << PHASE_W) - 1) << CORE_LSB) |
      (REG_W'((1 << PHASE_W) - 1) << BUS_LSB) |
      (REG_W'(1) << IDLE_DIS_BIT) |
      (REG_W'(1) << BUS_SEL_BIT);
  localparam logic [REG_W-1:0] RST_WORD = REG_W'(32) << BUS_LSB;

  typedef struct packed {
    logic               bus_sel;
    logic               idle_dis;
    logic [PHASE_W-1:0] bus_phase;
    logic [PHASE_W-1:0] core_phase;
  } cfg_t;
endpackage

// File: rtl/dce_cfg_reg.sv
module dce_cfg_reg
  import dce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cfg_t             cfg
);
  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= RST_WORD;
    else if (we) word_q <= wdata & WR_MASK;
  end

  assign rdata          = word_q;
  assign cfg.core_phase = word_q[CORE_LSB +: PHASE_W];
  assign cfg.bus_phase  = word_q[BUS_LSB +: PHASE_W];
  assign cfg.idle_dis   = word_q[IDLE_DIS_BIT];
  assign cfg.bus_sel    = word_q[BUS_SEL_BIT];
endmodule

// File: rtl/dce_rate_gen.sv
module dce_rate_gen #(
  parameter int            PW        = 6,
  parameter logic [PW-1:0] RST_PHASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_stb,
  input  logic [PW-1:0] req_phase,
  input  logic          req_div,
  output logic          stb,
  output logic [PW-1:0] act_phase_o,
  output logic          act_div_o
);
  logic [PW-1:0] act_phase, cnt;
  logic          act_div;
  logic [PW:0]   sum;
  logic          hit, cfg_new;

  always_comb begin
    sum = {1'b0, cnt} + {1'b0, act_phase};
    if (act_div)              hit = (cnt == act_phase);
    else if (act_phase == '0) hit = 1'b1;
    else                      hit = sum[PW];
  end

  assign cfg_new     = (req_phase != act_phase) || (req_div != act_div);
  assign stb         = src_stb & hit;
  assign act_phase_o = act_phase;
  assign act_div_o   = act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_phase <= RST_PHASE;
      act_div   <= 1'b0;
      cnt       <= '0;
    end else if (src_stb) begin
      if (hit) begin
        act_phase <= req_phase;
        act_div   <= req_div;
        if (act_div || cfg_new) cnt <= '0;
        else                    cnt <= sum[PW-1:0];
      end else if (act_div) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= sum[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/dual_clk_enable_gen.sv
module dual_clk_enable_gen
  import dce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [1:0]       rate_mode,
  input  logic             idle,
  output logic             core_stb,
  output logic             bus_stb,
  output logic             phase_err
);
  localparam logic [PHASE_W-1:0] MAX_ACC = PHASE_W'(1 << (PHASE_W - 1));

  cfg_t               cfg;
  logic [PHASE_W-1:0] core_req, bus_req;
  logic               core_bad, bus_bad, err_q;
  logic               bus_src, bus_raw;
  logic [PHASE_W-1:0] core_act_phase, bus_act_phase;
  logic               core_act_div, bus_act_div;

  dce_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  // Illegal accumulator phases are clamped before they reach a generator.
  assign core_bad = !rate_mode[0] && (cfg.core_phase > MAX_ACC);
  assign bus_bad  = !rate_mode[1] && (cfg.bus_phase > MAX_ACC);
  assign core_req = core_bad ? MAX_ACC : cfg.core_phase;
  assign bus_req  = bus_bad ? MAX_ACC : cfg.bus_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | core_bad | bus_bad;
  end
  assign phase_err = err_q;

  dce_rate_gen #(.PW(PHASE_W), .RST_PHASE('0)) u_core (
    .clk(clk), .rst_n(rst_n), .src_stb(1'b1),
    .req_phase(core_req), .req_div(rate_mode[0]),
    .stb(core_stb), .act_phase_o(core_act_phase), .act_div_o(core_act_div)
  );

  assign bus_src = cfg.bus_sel ? core_stb : 1'b1;

  dce_rate_gen #(.PW(PHASE_W), .RST_PHASE(MAX_ACC)) u_bus (
    .clk(clk), .rst_n(rst_n), .src_stb(bus_src),
    .req_phase(bus_req), .req_div(rate_mode[1]),
    .stb(bus_raw), .act_phase_o(bus_act_phase), .act_div_o(bus_act_div)
  );

  // The generator keeps running in idle; only the strobe is masked.
  assign bus_stb = bus_raw & ~(idle & cfg.idle_dis);
endmodule

// File: rtl/dce_checker.sv
module dce_checker
  import dce_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               idle,
  input logic [1:0]         rate_mode,
  input logic [REG_W-1:0]   cfg_rdata,
  input logic               core_stb,
  input logic               bus_stb,
  input logic               bus_raw,
  input logic               phase_err,
  input logic [PHASE_W-1:0] core_act_phase,
  input logic               core_act_div,
  input logic [PHASE_W-1:0] bus_act_phase,
  input logic               bus_act_div
);
  localparam logic [PHASE_W-1:0] MAX_ACC = PHASE_W'(1 << (PHASE_W - 1));

  p_idle_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cfg_rdata[IDLE_DIS_BIT]) |-> !bus_stb);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> phase_err);

  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_mode[0] && cfg_rdata[CORE_LSB +: PHASE_W] > MAX_ACC) |=> phase_err);

  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_act_div |-> (core_act_phase <= MAX_ACC));

  p_bus_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[BUS_SEL_BIT] && !core_stb) |-> !bus_stb);

  p_core_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({core_act_phase, core_act_div}) |-> $past(core_stb));

  p_bus_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({bus_act_phase, bus_act_div}) |-> $past(bus_raw));
endmodule

bind dual_clk_enable_gen dce_checker u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .rate_mode(rate_mode),
  .cfg_rdata(cfg_rdata), .core_stb(core_stb), .bus_stb(bus_stb),
  .bus_raw(bus_raw), .phase_err(phase_err),
  .core_act_phase(core_act_phase), .core_act_div(core_act_div),
  .bus_act_phase(bus_act_phase), .bus_act_div(bus_act_div)
);

// File: tb/dual_clk_enable_gen_test.sv
module dual_clk_enable_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  rate_mode = 2'b00;
  logic        idle = 1'b0;
  logic        core_stb, bus_stb, phase_err;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dual_clk_enable_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rate_mode(rate_mode), .idle(idle),
    .core_stb(core_stb), .bus_stb(bus_stb), .phase_err(phase_err)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  task automatic count(input int w, output int nc, output int nb);
    nc = 0; nb = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      nc += int'(core_stb);
      nb += int'(bus_stb);
    end
  endtask

  function automatic logic [31:0] word(input bit sel, input bit dis,
                                       input int bp, input int cp);
    return {16'h0, sel, dis, bp[5:0], 2'b00, cp[5:0]};
  endfunction

  function automatic int win(input bit div, input int p);
    return div ? 8 * (p + 1) : 64;
  endfunction

  function automatic int exp_cnt(input bit div, input int p, input int w);
    int pe;
    if (div) return w / (p + 1);
    pe = (p > 32) ? 32 : p;
    if (pe == 0) return w;
    return w * pe / 64;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int nc, nb, d;
    bit exp_err;
    do_reset();
    @(negedge clk);
    check("R6 reset word", cfg_rdata == 32'h0000_2000, cfg_rdata, 32'h2000);
    check("R6 reset err", phase_err == 1'b0, phase_err, 0);
    count(64, nc, nb);
    check("R6/R2 core pass-through after reset", nc == 64, nc, 64);
    check("R6/R1 bus phase 32 after reset", nb == 32, nb, 32);

    wr(32'hFFFF_FFFF);
    @(negedge clk);
    check("R5 reserved bits read 0", cfg_rdata == 32'h0000_FF3F, cfg_rdata, 32'hFF3F);

    // R1 R2 R4: sweep every phase in both modes, both generators
    do_reset();
    exp_err = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 64; p++) begin
        rate_mode = {m[0], m[0]};
        wr(word(1'b0, 1'b0, p, p));
        settle();
        exp_err |= (m == 0 && p > 32);
        count(win(m[0], p), nc, nb);
        check(m ? "R4 core divider" : "R1 core accumulator", nc == exp_cnt(m[0], p, win(m[0], p)), nc, exp_cnt(m[0], p, win(m[0], p)));
        check(m ? "R4 bus divider" : "R1 bus accumulator", nb == exp_cnt(m[0], p, win(m[0], p)), nb, exp_cnt(m[0], p, win(m[0], p)));
        check("R3 sticky err in sweep", phase_err == exp_err, phase_err, exp_err);
      end
    end

    // R3: clamp and sticky flag
    do_reset();
    rate_mode = 2'b00;
    wr(word(1'b0, 1'b0, 32, 40));
    settle();
    count(64, nc, nb);
    check("R3 clamped core rate", nc == 32, nc, 32);
    check("R3 err raised", phase_err == 1'b1, phase_err, 1);
    wr(word(1'b0, 1'b0, 32, 5));
    settle();
    check("R3 err stays set", phase_err == 1'b1, phase_err, 1);
    do_reset();
    @(negedge clk);
    check("R3 err cleared by reset", phase_err == 1'b0, phase_err, 0);

    // R9: independent modes
    rate_mode = 2'b01;
    wr(word(1'b0, 1'b0, 3, 3));
    settle();
    count(64, nc, nb);
    check("R9 core divider by 4", nc == 16, nc, 16);
    check("R9 bus accumulator phase 3", nb == 3, nb, 3);

    // R7: bus sourced from core strobe
    do_reset();
    rate_mode = 2'b11;
    wr(word(1'b1, 1'b0, 1, 1));
    settle();
    count(64, nc, nb);
    check("R7 core div2", nc == 32, nc, 32);
    check("R7 bus div2 of core", nb == 16, nb, 16);
    do_reset();
    rate_mode = 2'b00;
    wr(word(1'b1, 1'b0, 32, 16));
    settle();
    count(64, nc, nb);
    check("R7 bus acc 32 of core acc 16", nb == 8, nb, 8);

    // R8: idle gating
    do_reset();
    rate_mode = 2'b11;
    wr(word(1'b0, 1'b1, 1, 0));
    settle();
    idle = 1'b1;
    count(64, nc, nb);
    check("R8 bus held in idle", nb == 0, nb, 0);
    check("R8 core unaffected by idle", nc == 64, nc, 64);
    wr(word(1'b0, 1'b0, 1, 0));
    count(64, nc, nb);
    check("R8 idle ignored when disable bit clear", nb == 32, nb, 32);
    idle = 1'b0;

    // R10: no runt strobe across a setting change
    do_reset();
    rate_mode = 2'b01;
    wr(word(1'b0, 1'b0, 32, 9));
    settle();
    begin
      int last, bad, seen;
      last = -1; bad = 0; seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (i == 53) begin cfg_we = 1'b1; cfg_wdata = word(1'b0, 1'b0, 32, 3); end
        else cfg_we = 1'b0;
        if (core_stb) begin
          d = i - last;
          if (last >= 0 && d != 10 && d != 4) bad++;
          last = i; seen++;
        end
      end
      check("R10 strobe gaps are whole periods", bad == 0 && seen > 50, bad, 0);
    end

    // Constrained random settings, bus from clock source
    void'($urandom(32'd2024));
    for (int k = 0; k < 24; k++) begin
      int cp, bp; bit dis, idl; logic [1:0] md;
      cp = int'($urandom_range(0, 63));
      bp = int'($urandom_range(0, 63));
      md = 2'($urandom_range(0, 3));
      dis = 1'($urandom_range(0, 1));
      idl = 1'($urandom_range(0, 1));
      do_reset();
      rate_mode = md;
      wr(word(1'b0, dis, bp, cp));
      idle = idl;
      settle();
      count(win(md[0], cp), nc, nb);
      check(md[0] ? "R4/R9 random core" : "R1/R9 random core", nc == exp_cnt(md[0], cp, win(md[0], cp)), nc, exp_cnt(md[0], cp, win(md[0], cp)));
      count(win(md[1], bp), nc, nb);
      d = (dis && idl) ? 0 : exp_cnt(md[1], bp, win(md[1], bp));
      check("R8/R9 random bus", nb == d, nb, d);
      idle = 1'b0;
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule